// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block converts a column address and a page address into the series of address bytes that a NAND flash device expects on its 8-bit bus. It handles two page sizes: small pages of 512 bytes and large pages of 2048 bytes. It has an erase mode that sends only the page (row) address. For 16-bit devices it halves the column, because those parts count the column in words rather than bytes.

Before each transfer, the surrounding command engine sets the mode inputs and the number of address cycles that suit the device's capacity, then pulses `start`. The sequencer presents one byte at a time with `addr_valid`, which also serves as the address-latch qualifier. It advances only when the pin-timing stage downstream answers with `addr_ready`. After the last byte is accepted it raises `done` for a single clock.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset `addr_valid` and `done` are both low.
- R2: In large-page read/write mode (`large_page`=1, `erase`=0) the bytes go out in this order: column[7:0], then {4'b0000, column[11:8]}, then page[7:0], page[15:8] and page[23:16].
- R3: In small-page read/write mode (`large_page`=0, `erase`=0) the bytes go out in this order: column[7:0], page[7:0], page[15:8], page[23:16], then a zero byte.
- R4: In erase mode (`erase`=1) no column byte is sent, whatever the page size. The bytes are page[7:0], page[15:8] and page[23:16], followed by zero bytes.
- R5: When `wide_bus`=1 the column is shifted right by one bit before it is packed under R2 or R3. The shift has no effect in erase mode.
- R6: A sequence sends exactly `num_cycles` bytes. A value of 0 is treated as 1, and values above 5 are treated as 5.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_byte` and `addr_valid` hold steady. A byte is consumed only in a cycle where both are high.
- R8: `done` is high for exactly one cycle: the cycle after the final byte is accepted. In that cycle `addr_valid` is low.
- R9: A `start` that arrives while a sequence is in progress is ignored. The current sequence continues with its original bytes and count.
- R10: A `start` sampled while idle, including in the `done` cycle, makes `addr_valid` high in the next cycle with the first byte on `addr_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| large_page | input | 1 | 1 = 2048-byte page layout, 0 = 512-byte layout |
| erase | input | 1 | 1 = send the page address only |
| wide_bus | input | 1 | 1 = 16-bit device, so the column is halved |
| num_cycles | input | 3 | Number of address bytes to send (clamped to 1..5) |
| column | input | 12 | Column address in bytes |
| page | input | 24 | Page (row) address |
| addr_ready | input | 1 | Downstream accepts the current byte |
| addr_byte | output | 8 | Address byte currently presented |
| addr_valid | output | 1 | Byte valid; also the address-latch qualifier |
| done | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
Each byte order is checked by itself, together with the column halving and the count clamping, so a wrong or corrupted shift register shows up on `addr_byte` at the very next handshake. A fault in the remaining-byte counter shows up at the ports as one byte too many or too few: `done` arrives early or late, or `addr_valid` stays high, within one cycle of the expected final handshake. Stalls and a `start` injected in the middle of a sequence confirm that the held byte and the count survive both. A start issued in the `done` cycle confirms that the sequencer leaves no dead cycle between sequences.

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int COL_W    = 12,
  parameter int PAGE_W   = 24,
  parameter int MAX_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              large_page,
  input  logic              erase,
  input  logic              wide_bus,
  input  logic [2:0]        num_cycles,
  input  logic [COL_W-1:0]  column,
  input  logic [PAGE_W-1:0] page,
  input  logic              addr_ready,
  output logic [7:0]        addr_byte,
  output logic              addr_valid,
  output logic              done
);
  localparam int SH_W  = MAX_CYC * 8;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [SH_W-1:0]  shreg, packed_bytes;
  logic [CNT_W-1:0] remain, cnt_eff;
  logic [COL_W-1:0] col_eff;
  logic             fire, last;

  assign col_eff = wide_bus ? (column >> 1) : column;
  assign fire    = addr_valid && addr_ready;
  assign last    = fire && (remain == CNT_W'(1));

  always_comb begin
    packed_bytes = '0;
    if (erase)
      packed_bytes[PAGE_W-1:0] = page;
    else if (large_page)
      packed_bytes = SH_W'({page, 4'h0, col_eff[11:8], col_eff[7:0]});
    else
      packed_bytes = SH_W'({page, col_eff[7:0]});
  end

  always_comb begin
    if (num_cycles == 3'd0)
      cnt_eff = CNT_W'(1);
    else if (int'(num_cycles) > MAX_CYC)
      cnt_eff = CNT_W'(MAX_CYC);
    else
      cnt_eff = CNT_W'(num_cycles);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      remain     <= '0;
      addr_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= last;
      if (!addr_valid && start) begin
        shreg      <= packed_bytes;
        remain     <= cnt_eff;
        addr_valid <= 1'b1;
      end else if (fire) begin
        shreg      <= shreg >> 8;
        remain     <= remain - CNT_W'(1);
        addr_valid <= !last;
      end
    end
  end

  assign addr_byte = shreg[7:0];

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_byte)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && start |=> $stable(remain) && $stable(shreg)); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done && !addr_valid); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (remain >= CNT_W'(1)) && (int'(remain) <= MAX_CYC)); // R6
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid && start |=> addr_valid); // R10
endmodule

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0;
  logic        large_page = 0, erase = 0, wide_bus = 0, addr_ready = 0;
  logic [2:0]  num_cycles = 0;
  logic [11:0] column = 0;
  logic [23:0] page = 0;
  logic [7:0]  addr_byte;
  logic        addr_valid, done;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .large_page(large_page),
    .erase(erase), .wide_bus(wide_bus), .num_cycles(num_cycles),
    .column(column), .page(page), .addr_ready(addr_ready),
    .addr_byte(addr_byte), .addr_valid(addr_valid), .done(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] expect_bytes(input bit lp, input bit er,
      input bit wd, input logic [11:0] col, input logic [23:0] pg);
    logic [11:0] c;
    c = wd ? {1'b0, col[11:1]} : col;
    if (er) return {16'h0, pg[23:16], pg[15:8], pg[7:0]};
    if (lp) return {pg[23:16], pg[15:8], pg[7:0], 4'h0, c[11:8], c[7:0]};
    return {8'h0, pg[23:16], pg[15:8], pg[7:0], c[7:0]};
  endfunction

  // Called at a negedge; returns at the negedge where done should be high.
  task automatic run_seq(input bit lp, input bit er, input bit wd,
      input logic [2:0] cnt, input logic [11:0] col, input logic [23:0] pg,
      input bit stall, input bit poke, input string tag);
    logic [39:0] exp;
    int n;
    exp = expect_bytes(lp, er, wd, col, pg);
    n = (cnt == 0) ? 1 : (cnt > 5 ? 5 : int'(cnt));
    large_page = lp; erase = er; wide_bus = wd; num_cycles = cnt;
    column = col; page = pg; start = 1; addr_ready = 0;
    @(negedge clk);
    start = 0;
    chk(addr_valid, {tag, " R10 valid after start"}, addr_valid, 1);
    chk(!done, {tag, " R8 done single pulse"}, done, 0);
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        if (poke && i == 0) begin
          large_page = ~lp; erase = ~er; num_cycles = 3'd1;
          column = ~col; page = ~pg; start = 1;
        end
        @(negedge clk);
        start = 0;
        chk(addr_valid && addr_byte == exp[i*8 +: 8],
            {tag, poke ? " R9 start ignored" : " R7 hold on stall"}, addr_byte, exp[i*8 +: 8]);
      end
      chk(addr_valid && addr_byte == exp[i*8 +: 8], {tag, " byte R2 R3 R4 R5"},
          addr_byte, exp[i*8 +: 8]);
      addr_ready = 1;
      @(negedge clk);
      addr_ready = 0;
    end
    chk(done && !addr_valid, {tag, " R6 R8 done after last byte"}, {done, addr_valid}, 2'b10);
  endtask

  task automatic t_reset();
    chk(!addr_valid && !done, "R1 reset state", {addr_valid, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_seq(1, 0, 0, 3'd5, 12'h9A5, 24'hC3B2A1, 0, 0, "large5 R2");
    run_seq(1, 0, 1, 3'd4, 12'h9A5, 24'h123456, 1, 0, "large4 wide R5");
    run_seq(0, 0, 0, 3'd4, 12'h03C, 24'h876543, 0, 0, "small4 R3");
    run_seq(0, 0, 1, 3'd3, 12'h07E, 24'h00A5F0, 1, 0, "small3 wide R5");
    run_seq(1, 1, 1, 3'd3, 12'hFFF, 24'h5A6B7C, 0, 0, "erase large R4");
    run_seq(0, 1, 0, 3'd2, 12'hABC, 24'h010203, 0, 0, "erase small R4");
    run_seq(1, 0, 0, 3'd0, 12'h345, 24'h999999, 0, 0, "clamp0 R6");
    run_seq(0, 0, 0, 3'd7, 12'h0EE, 24'hFEDCBA, 0, 0, "clamp7 R6");
    run_seq(1, 0, 0, 3'd5, 12'h6D1, 24'h0F1E2D, 1, 1, "poke R9");
    @(negedge clk);
    chk(!done && !addr_valid, "R8 done drops", {done, addr_valid}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule